// File: doc/BRIEF.md
# Static Memory Access Sequencer

This block turns single requests from an internal master into timed cycles on an external asynchronous static memory bus. Every access runs as a setup phase, a pulse phase and a hold phase. Each phase lasts a number of controller clocks taken from a timing word stored separately for each chip select. The block drives the active-low chip selects, the write strobe, the read strobe and the two byte-lane selects. It also drives the address lines and a 16-bit data path, split into an output with an enable and a separate input.

A write can be issued with chip select as the controlling strobe or with the write strobe as the controlling strobe, chosen per chip select. When a read follows a write on the same chip select with no gap, and the write's controlling strobe has no hold time, the block may add one idle cycle. During that cycle address, data, chip select and byte selects stay at their write values, so the write finishes cleanly before the read drives the bus. When an access follows another on a different chip select with no gap, the block adds one fully quiet cycle instead. The two kinds of idle cycle are never stacked.

Top module: `smem_seq`

## Requirements
- R1: While reset is held and directly after it, every chip select, the write strobe, the read strobe and every byte select are high, the data output enable is low, `rd_valid` is low and `req_ready` is high.
- R2: An access with setup count S, pulse field P and hold count H lasts S + (P+1) + H clocks in that order. A setup or hold count of zero removes that phase.
- R3: In a write with mode bit 0, chip select is low only during the pulse phase and the write strobe is low in all three phases. With mode bit 1, chip select is low in all three phases and the write strobe only in the pulse. Byte select n is low exactly when chip select is low and mask bit n is set. `mem_dout` carries the write data while `mem_dout_en` is high.
- R4: In a read, chip select is low in all phases and the read strobe only in the pulse. `mem_din` is captured in the last pulse clock and shown on `rd_data` with `rd_valid` high for the single following clock. The write and read strobes are never low together.
- R5: `req_ready` is high when idle and in the final clock of an access. A request accepted in that final clock starts on the next clock with no gap, unless R6, R7 or R8 applies.
- R6: An access accepted in the final clock of an access to a different chip select is preceded by one idle clock. In that clock all strobes are high and the address lines keep the previous value.
- R7: A read accepted in the final clock of a write to the same chip select, with mode bit 0, write hold 0 and read setup 0, is preceded by one early-read idle clock.
- R8: With mode bit 1 and write hold 0, the same write-to-read case gets the early-read idle clock whatever the read setup. In that clock address, write data, chip select and byte selects keep their write values, and the write and read strobes are high.
- R9: A write-to-read turnaround on the same chip select that meets neither R7 nor R8 starts the read on the next clock.
- R10: Exactly one idle clock is ever inserted between two accesses, and `req_ready` is low during it.
- R11: A pulse of `cfg_we` stores `cfg_word` as the timing of chip select `cfg_sel`. The field layout is: bits [3:0] write setup, [7:4] write pulse, [11:8] write hold, [15:12] read setup, [19:16] read pulse, [23:20] read hold, and bit 24 the write mode. Each chip select uses only its own word, and chip select i drives `mem_cs_n[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Store the timing word |
| cfg_sel | input | CSW | Chip select whose timing is stored |
| cfg_word | input | 25 | Packed timing word (layout in R11) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this clock |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | CSW | Target chip select |
| req_addr | input | AW | Target address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte lane mask, 1 = lane used |
| rd_valid | output | 1 | One-clock read data strobe |
| rd_data | output | DW | Captured read data |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_bs_n | output | DW/8 | Active-low byte selects |
| mem_addr | output | AW | Address lines |
| mem_dout | output | DW | Write data lines |
| mem_dout_en | output | 1 | Data output enable |
| mem_din | input | DW | Read data lines |

## Verification
A wrong phase counter shows within the same access as a strobe edge one clock early or late. The cycle-by-cycle strobe trace exposes it before the next request is taken. A wrong turnaround decision shows in the first clock after a write ends: either a missing idle clock, in which the read strobe falls while chip select and address still belong to the write, or a spurious one that shifts the whole read by a clock. A read captured from the wrong clock returns data belonging to another address on the clock `rd_valid` rises.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam int TW    = 4;
  localparam int CFG_W = 6 * TW + 1;

  // bit 24 mode, then rd hold/pulse/setup, then wr hold/pulse/setup at the bottom
  typedef struct packed {
    logic          wmode;
    logic [TW-1:0] rd_hold;
    logic [TW-1:0] rd_pulse;
    logic [TW-1:0] rd_setup;
    logic [TW-1:0] wr_hold;
    logic [TW-1:0] wr_pulse;
    logic [TW-1:0] wr_setup;
  } tcfg_t;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_WAIT} phase_t;
  typedef enum logic [1:0] {GAP_NONE, GAP_CSCHG, GAP_EARLY} gap_t;

  function automatic logic [TW-1:0] f_setup(input tcfg_t t, input logic wr);
    return wr ? t.wr_setup : t.rd_setup;
  endfunction

  function automatic logic [TW-1:0] f_pulse(input tcfg_t t, input logic wr);
    return wr ? t.wr_pulse : t.rd_pulse;
  endfunction

  function automatic logic [TW-1:0] f_hold(input tcfg_t t, input logic wr);
    return wr ? t.wr_hold : t.rd_hold;
  endfunction

  function automatic phase_t f_entry(input tcfg_t t, input logic wr);
    return (f_setup(t, wr) != '0) ? PH_SETUP : PH_PULSE;
  endfunction

  // counter value loaded on entering the first phase (remaining clocks minus one)
  function automatic logic [TW-1:0] f_entry_cnt(input tcfg_t t, input logic wr);
    return (f_setup(t, wr) != '0) ? f_setup(t, wr) - 1'b1 : f_pulse(t, wr);
  endfunction

  // idle-clock decision for a request taken in the final clock of the previous access
  function automatic gap_t f_gap(input logic adjacent, input logic same_cs,
                                 input logic prev_wr, input logic new_wr,
                                 input logic [TW-1:0] prev_hold, input logic prev_mode,
                                 input logic [TW-1:0] new_rd_setup);
    if (!adjacent)     return GAP_NONE;
    if (!same_cs)      return GAP_CSCHG;
    if (prev_wr && !new_wr && prev_hold == '0 && (prev_mode || new_rd_setup == '0))
      return GAP_EARLY;
    return GAP_NONE;
  endfunction

endpackage

// File: rtl/smem_cfg_bank.sv
module smem_cfg_bank
  import smem_pkg::*;
#(
  parameter int NCS = 2,
  parameter int CSW = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSW-1:0]   wr_sel,
  input  logic [CFG_W-1:0] wr_word,
  output tcfg_t            tab [NCS]
);

  for (genvar g = 0; g < NCS; g++) begin : g_slot
    tcfg_t slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot_q <= '0;
      else if (wr_en && wr_sel == CSW'(g))    slot_q <= tcfg_t'(wr_word);
    end
    assign tab[g] = slot_q;
  end

endmodule

// File: rtl/smem_strobe_gen.sv
module smem_strobe_gen
  import smem_pkg::*;
#(
  parameter int NCS = 2,
  parameter int CSW = 1,
  parameter int BW  = 2
) (
  input  phase_t          phase,
  input  gap_t            gap,
  input  logic            is_wr,
  input  logic            wmode,
  input  logic [CSW-1:0]  cs_idx,
  input  logic [BW-1:0]   be,
  output logic [NCS-1:0]  cs_n,
  output logic            we_n,
  output logic            rd_n,
  output logic [BW-1:0]   bs_n,
  output logic            dout_en
);

  logic in_access, in_pulse, early_wait, cs_on;
  logic [NCS-1:0] cs_onehot;

  assign in_access  = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
  assign in_pulse   = (phase == PH_PULSE);
  assign early_wait = (phase == PH_WAIT) && (gap == GAP_EARLY);
  assign cs_onehot  = {{(NCS-1){1'b0}}, 1'b1} << cs_idx;

  always_comb begin
    cs_on = 1'b0;
    we_n  = 1'b1;
    rd_n  = 1'b1;
    if (in_access) begin
      if (is_wr) begin
        cs_on = wmode ? 1'b1 : in_pulse;
        we_n  = wmode ? !in_pulse : 1'b0;
      end else begin
        cs_on = 1'b1;
        rd_n  = !in_pulse;
      end
    end else if (early_wait) begin
      cs_on = 1'b1;
    end
  end

  assign cs_n    = cs_on ? ~cs_onehot : '1;
  assign bs_n    = cs_on ? ~be : '1;
  assign dout_en = (in_access && is_wr) || early_wait;

endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
#(
  parameter int NCS = 2,
  parameter int AW  = 24,
  parameter int DW  = 16,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int BW  = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CSW-1:0]   cfg_sel,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [CSW-1:0]   req_cs,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [BW-1:0]    req_be,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [NCS-1:0]   mem_cs_n,
  output logic             mem_we_n,
  output logic             mem_rd_n,
  output logic [BW-1:0]    mem_bs_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_dout_en,
  input  logic [DW-1:0]    mem_din
);

  tcfg_t cfg_tab [NCS];

  smem_cfg_bank #(.NCS(NCS), .CSW(CSW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_word(cfg_word), .tab(cfg_tab)
  );

  // access currently on the bus
  phase_t          phase;
  logic [TW-1:0]   cnt;
  tcfg_t           cur;
  logic            bus_wr;
  logic [CSW-1:0]  bus_cs;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata;
  logic [BW-1:0]   bus_be;
  gap_t            gap_q;
  // access parked behind an idle clock
  tcfg_t           job_t;
  logic            job_wr;
  logic [CSW-1:0]  job_cs;
  logic [AW-1:0]   job_addr;
  logic [DW-1:0]   job_wdata;
  logic [BW-1:0]   job_be;

  // named internal events
  tcfg_t req_t;
  logic  last_cyc, accept, capture_rd;
  gap_t  gap_new;

  assign req_t      = cfg_tab[req_cs];
  assign last_cyc   = (phase == PH_PULSE && cnt == '0 && f_hold(cur, bus_wr) == '0) ||
                      (phase == PH_HOLD  && cnt == '0);
  assign req_ready  = (phase == PH_IDLE) || last_cyc;
  assign accept     = req_valid && req_ready;
  assign capture_rd = (phase == PH_PULSE) && (cnt == '0) && !bus_wr;
  assign gap_new    = f_gap(phase != PH_IDLE, req_cs == bus_cs, bus_wr, req_write,
                            cur.wr_hold, cur.wmode, req_t.rd_setup);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;   cnt <= '0;        cur <= '0;
      bus_wr <= 1'b0;     bus_cs <= '0;     bus_addr <= '0;
      bus_wdata <= '0;    bus_be <= '0;     gap_q <= GAP_NONE;
      job_t <= '0;        job_wr <= 1'b0;   job_cs <= '0;
      job_addr <= '0;     job_wdata <= '0;  job_be <= '0;
      rd_valid <= 1'b0;   rd_data <= '0;
    end else begin
      rd_valid <= capture_rd;
      if (capture_rd) rd_data <= mem_din;
      if (accept) begin
        if (gap_new != GAP_NONE) begin
          phase <= PH_WAIT;   gap_q <= gap_new;
          job_t <= req_t;     job_wr <= req_write;  job_cs <= req_cs;
          job_addr <= req_addr; job_wdata <= req_wdata; job_be <= req_be;
        end else begin
          cur <= req_t;       bus_wr <= req_write;  bus_cs <= req_cs;
          bus_addr <= req_addr; bus_wdata <= req_wdata; bus_be <= req_be;
          phase <= f_entry(req_t, req_write);
          cnt   <= f_entry_cnt(req_t, req_write);
        end
      end else if (last_cyc) begin
        phase <= PH_IDLE;
      end else begin
        case (phase)
          PH_SETUP: if (cnt == '0) begin
                      phase <= PH_PULSE;
                      cnt   <= f_pulse(cur, bus_wr);
                    end else cnt <= cnt - 1'b1;
          PH_PULSE: if (cnt == '0) begin
                      phase <= PH_HOLD;
                      cnt   <= f_hold(cur, bus_wr) - 1'b1;
                    end else cnt <= cnt - 1'b1;
          PH_HOLD:  cnt <= cnt - 1'b1;
          PH_WAIT:  begin
                      cur <= job_t;       bus_wr <= job_wr;   bus_cs <= job_cs;
                      bus_addr <= job_addr; bus_wdata <= job_wdata; bus_be <= job_be;
                      phase <= f_entry(job_t, job_wr);
                      cnt   <= f_entry_cnt(job_t, job_wr);
                    end
          default:  ;
        endcase
      end
    end
  end

  smem_strobe_gen #(.NCS(NCS), .CSW(CSW), .BW(BW)) u_strb (
    .phase(phase), .gap(gap_q), .is_wr(bus_wr), .wmode(cur.wmode),
    .cs_idx(bus_cs), .be(bus_be), .cs_n(mem_cs_n), .we_n(mem_we_n),
    .rd_n(mem_rd_n), .bs_n(mem_bs_n), .dout_en(mem_dout_en)
  );

  assign mem_addr = bus_addr;
  assign mem_dout = bus_wdata;

  // ---------------- assertions ----------------
  assert_one_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_rd_n));

  assert_rdv_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_rd_n));

  assert_single_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |=> (phase != PH_WAIT));

  assert_idle_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |-> !req_ready);

  assert_early_keeps_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && gap_q == GAP_EARLY) |->
      ($stable(mem_addr) && $stable(mem_cs_n) && $stable(mem_bs_n) &&
       $stable(mem_dout) && mem_we_n && mem_rd_n));

  assert_cs_change_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && gap_q == GAP_CSCHG) |->
      ((&mem_cs_n) && mem_we_n && mem_rd_n && $stable(mem_addr)));

endmodule

// File: tb/smem_seq_test.sv
module smem_seq_test;
  import smem_pkg::*;

  localparam int NT = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_sel = '0;
  logic [24:0] cfg_word = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [0:0]  req_cs = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        req_ready, rd_valid, mem_we_n, mem_rd_n, mem_dout_en;
  logic [15:0] rd_data, mem_dout, mem_din;
  logic [1:0]  mem_cs_n, mem_bs_n;
  logic [23:0] mem_addr;

  int total = 0, bad = 0;

  always #5 clk = ~clk;
  assign mem_din = {8'hA5, mem_addr[7:0]};

  smem_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_rd_n(mem_rd_n),
    .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  // cfg0, cfg1, first access (write, cs), second access (write, cs), expected idle kind
  // idle kind: 0 none, 1 early-read hold, 2 chip-select change
  typedef struct packed {
    logic [24:0] c0;
    logic [24:0] c1;
    logic        aw;
    logic        acs;
    logic        bw;
    logic        bcs;
    logic [1:0]  gap;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{25'h0110011, 25'h0000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
    '{25'h0111011, 25'h0000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    '{25'h0110111, 25'h0000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    '{25'h1112011, 25'h0000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
    '{25'h1110111, 25'h0000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    '{25'h0110011, 25'h0220022, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2},
    '{25'h0110011, 25'h0000000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{25'h0110011, 25'h0000000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0},
    '{25'h0110011, 25'h0220022, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2},
    '{25'h1000000, 25'h0000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
    '{25'h0000000, 25'h0000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
    '{25'h0000000, 25'h1003100, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0}
  };

  function automatic string vtag(input int v);
    case (v)
      0, 10:        return "R7";
      3, 9:         return "R8";
      1, 2, 4, 11:  return "R9";
      5, 8:         return "R6 R11";
      default:      return "R5";
    endcase
  endfunction

  // expected trace code: [12] rd_valid, [11:10] cs low per select, [9] we low, [8] rd low, [7:0] addr
  logic [12:0] exp_code [NT];
  logic [7:0]  exp_ra   [NT];
  logic        rdv_mark [NT];
  int          widx;

  task automatic push(input logic [12:0] code);
    if (widx < NT) exp_code[widx] = code;
    widx++;
  endtask

  task automatic model_acc(input logic wr, input logic cs, input logic [24:0] c,
                           input logic [7:0] a);
    logic [3:0] s, p, h;
    logic       m, side_cs, side_we;
    logic [1:0] csb;
    s = wr ? c[3:0]  : c[15:12];
    p = wr ? c[7:4]  : c[19:16];
    h = wr ? c[11:8] : c[23:20];
    m = c[24];
    csb = cs ? 2'b10 : 2'b01;
    side_cs = !(wr && !m);
    side_we = wr && !m;
    for (int i = 0; i < int'(s); i++) push({1'b0, side_cs ? csb : 2'b00, side_we, 1'b0, a});
    for (int i = 0; i <= int'(p); i++) push({1'b0, csb, wr, !wr, a});
    if (!wr && widx < NT) begin rdv_mark[widx] = 1'b1; exp_ra[widx] = a; end
    for (int i = 0; i < int'(h); i++) push({1'b0, side_cs ? csb : 2'b00, side_we, 1'b0, a});
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic sel, input logic [24:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input int v);
    vec_t e;
    logic [12:0] act;
    logic [7:0]  aa, ba;
    bit          acc, mism;
    int          first_k;
    logic [12:0] fa, fe;
    e  = VECS[v];
    aa = 8'h12 + 8'(v);
    ba = 8'h80 + 8'(v);
    set_cfg(1'b0, e.c0);
    set_cfg(1'b1, e.c1);
    for (int i = 0; i < NT; i++) begin rdv_mark[i] = 1'b0; exp_ra[i] = '0; end
    widx = 0;
    model_acc(e.aw, e.acs, e.acs ? e.c1 : e.c0, aa);
    if (e.gap == 2'd1) push({1'b0, e.acs ? 2'b10 : 2'b01, 1'b0, 1'b0, aa});
    else if (e.gap == 2'd2) push({1'b0, 2'b00, 1'b0, 1'b0, aa});
    model_acc(e.bw, e.bcs, e.bcs ? e.c1 : e.c0, ba);
    for (int i = widx; i < NT; i++) exp_code[i] = {1'b0, 2'b00, 1'b0, 1'b0, ba};
    for (int i = 0; i < NT; i++) exp_code[i][12] = rdv_mark[i];

    @(negedge clk);
    req_valid = 1'b1; req_write = e.aw; req_cs = e.acs; req_addr = {16'h0, aa};
    req_wdata = 16'h1000 + 16'(v); req_be = 2'b11;
    acc = 1'b0; mism = 1'b0; first_k = -1; fa = '0; fe = '0;
    for (int k = 0; k < NT; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_write = e.bw; req_cs = e.bcs; req_addr = {16'h0, ba};
        req_wdata = 16'h2000 + 16'(v);
      end else if (acc) begin
        req_valid = 1'b0; acc = 1'b0;
      end
      act = {rd_valid, ~mem_cs_n, ~mem_we_n, ~mem_rd_n, mem_addr[7:0]};
      if (act !== exp_code[k] && !mism) begin
        mism = 1'b1; first_k = k; fa = act; fe = exp_code[k];
      end
      if (rd_valid)
        check(rd_data === {8'hA5, exp_ra[k]}, "R4", $sformatf("vector %0d read data", v),
              32'(rd_data), {16'h0, 8'hA5, exp_ra[k]});
      if (req_valid && req_ready) acc = 1'b1;
    end
    req_valid = 1'b0;
    // every trace covers phase lengths (R2), strobe shapes (R3, R4) and the turnaround rule
    check(!mism, vtag(v), $sformatf("vector %0d trace at cycle %0d (R2 R3 R4)", v, first_k),
          32'(fa), 32'(fe));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state, during and right after reset
    repeat (2) @(negedge clk);
    check(mem_cs_n == 2'b11 && mem_we_n && mem_rd_n && mem_bs_n == 2'b11 &&
          !mem_dout_en && !rd_valid && req_ready, "R1", "strobes in reset",
          {25'h0, mem_cs_n, mem_we_n, mem_rd_n, mem_bs_n, mem_dout_en},
          {25'h0, 2'b11, 1'b1, 1'b1, 2'b11, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs_n == 2'b11 && mem_we_n && mem_rd_n && !rd_valid && req_ready,
          "R1", "strobes after reset",
          {27'h0, mem_cs_n, mem_we_n, mem_rd_n, req_ready}, {27'h0, 2'b11, 1'b1, 1'b1, 1'b1});

    for (int v = 0; v < NV; v++) begin
      run_vec(v);
      repeat (3) @(negedge clk);
    end

    // directed: early-read idle clock with zero timing, mode 1 (R8, R10)
    set_cfg(1'b0, 25'h1000000);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cs = 1'b0; req_addr = 24'h55;
    req_wdata = 16'hBEEF; req_be = 2'b01;
    @(negedge clk);
    check(!mem_we_n && req_ready, "R5", "one-clock write ready in last clock",
          {30'h0, mem_we_n, req_ready}, {30'h0, 1'b0, 1'b1});
    req_write = 1'b0; req_addr = 24'h66; req_wdata = 16'h0; req_be = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10", "ready during idle clock", 32'(req_ready), 32'd0);
    check(mem_cs_n == 2'b10 && mem_we_n && mem_rd_n && mem_bs_n == 2'b10,
          "R8", "strobes in early-read clock",
          {28'h0, mem_cs_n, mem_bs_n}, {28'h0, 2'b10, 2'b10});
    check(mem_addr == 24'h55 && mem_dout == 16'hBEEF && mem_dout_en, "R8",
          "address and data kept in early-read clock",
          {mem_addr[15:0], mem_dout}, {16'h0055, 16'hBEEF});
    @(negedge clk);
    check(!mem_rd_n && mem_addr == 24'h66 && mem_cs_n == 2'b10, "R4",
          "read pulse after idle clock", {8'h0, mem_addr[15:0], 7'h0, mem_rd_n},
          {8'h0, 16'h0066, 8'h00});
    @(negedge clk);
    check(rd_valid && rd_data == 16'hA566, "R4", "read data after idle clock",
          {15'h0, rd_valid, rd_data}, {15'h0, 1'b1, 16'hA566});
    @(negedge clk);
    check(!rd_valid, "R4", "read valid lasts one clock", 32'(rd_valid), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule